// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tags of a small set-associative cache whose entries are block numbers, and decides hit or miss for each request. A request carries a block number and a read/write flag. The low bits of the block number choose the set, which is the block number modulo the set count. The remaining bits form the tag. That tag is compared at once against every way of the chosen set. The result comes back one cycle later: hit or miss, the way that now holds the block, and whether a dirty line must be written back.

On a miss the block takes a way in the set and the new tag is installed in the same cycle. An empty way is always taken first. Only when the whole set is full is the least-recently-used way replaced. Writes only mark the line dirty. Evicting a dirty line raises a writeback flag that carries the evicted block number. Data arrays and the refill path are handled elsewhere.

The request side uses a valid-only stream with no back-pressure: a request is accepted on every cycle that `req_valid` is high. Exactly one response follows on the next cycle. Requests may be issued back to back, and each one sees the state left by the one before it. The number of ways is 2 or 4. The set count is a power of two of at least 2.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The set is the low log2(SETS) bits of `req_block`, and the tag is the remaining upper bits. Accesses to one set never change the contents of another set.
- R2: A request whose tag matches a valid way of its set reports `rsp_hit`=1, with `rsp_way` equal to that way's index.
- R3: Every cycle with `req_valid`=1 produces `rsp_valid`=1 on the following cycle with that request's result. A cycle with `req_valid`=0 produces `rsp_valid`=0 on the following cycle.
- R4: On a miss, if any way of the set is invalid, the lowest-numbered invalid way is filled and reported in `rsp_way`.
- R5: On a miss with every way valid, the least-recently-used way is replaced. Both hits and fills make the accessed way the most recent.
- R6: A write (hit or fill) marks the line dirty. A read hit leaves the dirty state unchanged, and a read fill installs a clean line.
- R7: A miss that replaces a valid dirty line gives `rsp_evict`=1, with `rsp_evict_block` equal to the evicted block number (its tag concatenated with the set index). Replacing a clean or invalid way gives `rsp_evict`=0.
- R8: A synchronous reset (`rst`=1) clears every valid and dirty bit and the response outputs. After reset, every block misses and no eviction is reported until the set is refilled.
- R9: With 2 sets of 2 ways, the read sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss.
- R10: Idle cycles (`req_valid`=0) change no tag, valid, dirty or recency state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle (always accepted) |
| req_block | input | BLOCK_W | Block number being accessed |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | 1 = tag found in the set |
| rsp_way | output | WAY_W | Way hit or filled |
| rsp_evict | output | 1 | Dirty line replaced; writeback needed |
| rsp_evict_block | output | BLOCK_W | Block number of the replaced dirty line |

## Verification
The main pattern is the classic conflict sequence in which every block maps to one set. It separates true associativity from direct mapping, because block 0 must hit on its second access. Interleaved traffic to the second set shows that the sets stay independent. Write-then-evict against read-then-evict patterns separate dirty tracking from plain replacement. Hits placed between fills move the recency order, which tells true LRU apart from fill-order (FIFO) replacement. A reset followed by refills separates lowest-invalid-first placement from LRU choice.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  // Width of an index able to address n items; at least one bit.
  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ctag_match.sv
module ctag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 7,
  localparam int WAY_W = cache_tag_pkg::idx_w(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]           look_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  // one comparator per way, all working in parallel
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_valid[g] && (way_tags[g] == look_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ctag_victim.sv
module ctag_victim #(
  parameter int WAYS = 2,
  localparam int WAY_W = cache_tag_pkg::idx_w(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][WAY_W-1:0] way_age,
  output logic [WAY_W-1:0]           victim
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  always_comb begin
    victim = '0;
    // fallback: the way with the largest age is least recently used
    for (int w = 0; w < WAYS; w++) begin
      if (way_age[w] == OLDEST) victim = WAY_W'(w);
    end
    // an empty way wins; scanning downward leaves the lowest index
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ctag_lru.sv
module ctag_lru #(
  parameter int WAYS = 2,
  parameter int SETS = 2,
  localparam int WAY_W = cache_tag_pkg::idx_w(WAYS),
  localparam int SET_W = cache_tag_pkg::idx_w(SETS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       touch,
  input  logic [SET_W-1:0]           set_sel,
  input  logic [WAY_W-1:0]           touch_way,
  output logic [WAYS-1:0][WAY_W-1:0] set_age
);
  // per-set age ranks: 0 = most recent, WAYS-1 = least recent
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAY_W-1:0] ref_age;

  assign set_age = age_q[set_sel];
  assign ref_age = age_q[set_sel][touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[set_sel][w] <= '0;
        else if (age_q[set_sel][w] < ref_age)
          age_q[set_sel][w] <= age_q[set_sel][w] + 1'b1;
      end
    end
  end

  // R5
  mru_zero_chk: assert property (@(posedge clk) disable iff (rst)
    touch |=> age_q[$past(set_sel)][$past(touch_way)] == '0);
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int WAYS    = 2,
  parameter int SETS    = 2,
  parameter int BLOCK_W = 8,
  localparam int WAY_W  = cache_tag_pkg::idx_w(WAYS),
  localparam int SET_W  = cache_tag_pkg::idx_w(SETS),
  localparam int TAG_W  = BLOCK_W - SET_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [BLOCK_W-1:0] req_block,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [WAY_W-1:0]   rsp_way,
  output logic               rsp_evict,
  output logic [BLOCK_W-1:0] rsp_evict_block
);
  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0]            dirty_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;

  logic [SET_W-1:0]            lk_set;
  logic [TAG_W-1:0]            lk_tag;
  logic [WAYS-1:0]             set_valid, set_dirty, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0]  set_tags;
  logic [WAYS-1:0][WAY_W-1:0]  set_age;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way, vic_way, acc_way;
  logic                        evict_now;

  assign lk_set    = req_block[SET_W-1:0];
  assign lk_tag    = req_block[BLOCK_W-1:SET_W];
  assign set_valid = valid_q[lk_set];
  assign set_dirty = dirty_q[lk_set];
  assign set_tags  = tag_q[lk_set];

  ctag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tags (set_tags),
    .way_valid(set_valid),
    .look_tag (lk_tag),
    .hit_vec  (hit_vec),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  ctag_victim #(.WAYS(WAYS)) u_victim (
    .way_valid(set_valid),
    .way_age  (set_age),
    .victim   (vic_way)
  );

  ctag_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .touch    (req_valid),
    .set_sel  (lk_set),
    .touch_way(acc_way),
    .set_age  (set_age)
  );

  assign acc_way   = hit ? hit_way : vic_way;
  assign evict_now = !hit && set_valid[vic_way] && set_dirty[vic_way];

  // line state and registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q         <= '0;
      dirty_q         <= '0;
      rsp_valid       <= 1'b0;
      rsp_hit         <= 1'b0;
      rsp_way         <= '0;
      rsp_evict       <= 1'b0;
      rsp_evict_block <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit         <= hit;
        rsp_way         <= acc_way;
        rsp_evict       <= evict_now;
        rsp_evict_block <= {set_tags[vic_way], lk_set};
        valid_q[lk_set][acc_way] <= 1'b1;
        dirty_q[lk_set][acc_way] <= hit ? (set_dirty[acc_way] | req_write)
                                        : req_write;
      end else begin
        rsp_hit         <= 1'b0;
        rsp_way         <= '0;
        rsp_evict       <= 1'b0;
        rsp_evict_block <= '0;
      end
    end
  end

  // tag store needs no reset: valid bits gate every match
  always_ff @(posedge clk) begin
    if (!rst && req_valid && !hit) tag_q[lk_set][vic_way] <= lk_tag;
  end

  // R7
  evict_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_evict |-> (rsp_valid && !rsp_hit));
  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R3
  no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(hit_vec));
  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_evict));
endmodule

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_block = '0;
  logic       req_write = 1'b0;
  logic       rsp_valid, rsp_hit, rsp_evict;
  logic [0:0] rsp_way;
  logic [7:0] rsp_evict_block;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cache_tag_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_block(req_block),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_evict(rsp_evict), .rsp_evict_block(rsp_evict_block)
  );

  // {write, block[7:0], exp_hit, exp_way, exp_evict, exp_evict_block[7:0]}
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 8'd0},
    {1'b0, 8'd8,  1'b0, 1'b1, 1'b0, 8'd0},
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0},
    {1'b0, 8'd6,  1'b0, 1'b1, 1'b0, 8'd0},
    {1'b0, 8'd8,  1'b0, 1'b0, 1'b0, 8'd0},
    {1'b1, 8'd1,  1'b0, 1'b0, 1'b0, 8'd0},
    {1'b0, 8'd3,  1'b0, 1'b1, 1'b0, 8'd0},
    {1'b0, 8'd1,  1'b1, 1'b0, 1'b0, 8'd0},
    {1'b1, 8'd6,  1'b1, 1'b1, 1'b0, 8'd0},
    {1'b0, 8'd10, 1'b0, 1'b0, 1'b0, 8'd0},
    {1'b0, 8'd12, 1'b0, 1'b1, 1'b1, 8'd6},
    {1'b0, 8'd5,  1'b0, 1'b1, 1'b0, 8'd0},
    {1'b0, 8'd7,  1'b0, 1'b0, 1'b1, 8'd1},
    {1'b0, 8'd12, 1'b1, 1'b1, 1'b0, 8'd0},
    {1'b0, 8'd10, 1'b1, 1'b0, 1'b0, 8'd0},
    {1'b0, 8'd14, 1'b0, 1'b1, 1'b0, 8'd0}
  };
  localparam string VEC_REQ [NV] = '{
    "R9", "R9", "R9", "R5", "R9", "R1", "R4", "R2",
    "R6", "R5", "R7", "R5", "R7", "R2", "R2", "R6"
  };

  task automatic do_req(input logic [7:0] b, input logic w);
    @(negedge clk);
    req_valid = 1'b1;
    req_block = b;
    req_write = w;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic chk(input string req, input logic h, input logic [0:0] way,
                     input logic ev, input logic [7:0] evb);
    tests++;
    if (!(rsp_valid === 1'b1 && rsp_hit === h && rsp_way === way &&
          rsp_evict === ev && (!ev || rsp_evict_block === evb))) begin
      fails++;
      $display("FAIL %s: got v=%0d hit=%0d way=%0d ev=%0d blk=%0d, expected v=1 hit=%0d way=%0d ev=%0d blk=%0d",
               req, rsp_valid, rsp_hit, rsp_way, rsp_evict, rsp_evict_block,
               h, way, ev, evb);
    end
  endtask

  task automatic chk_quiet(input string req);
    tests++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_evict !== 1'b0) begin
      fails++;
      $display("FAIL %s: got v=%0d hit=%0d ev=%0d, expected v=0 hit=0 ev=0",
               req, rsp_valid, rsp_hit, rsp_evict);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_quiet("R8");  // outputs cleared in reset
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      do_req(VEC[i][18:11], VEC[i][19]);
      chk(VEC_REQ[i], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end

    // R10: an idle cycle yields no response and leaves state alone
    @(negedge clk);
    @(posedge clk);
    #1;
    chk_quiet("R10");
    do_req(8'd14, 1'b0);
    chk("R10", 1'b1, 1'b1, 1'b0, 8'd0);
    do_req(8'd14, 1'b1);  // dirty line before reset
    chk("R6", 1'b1, 1'b1, 1'b0, 8'd0);

    // R8: reset mid-run wipes valid and dirty state
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk_quiet("R8");
    @(negedge clk);
    rst = 1'b0;
    do_req(8'd14, 1'b0);
    chk("R8", 1'b0, 1'b0, 1'b0, 8'd0);
    do_req(8'd10, 1'b0);
    chk("R4", 1'b0, 1'b1, 1'b0, 8'd0);
    do_req(8'd2, 1'b0);
    chk("R8", 1'b0, 1'b0, 1'b0, 8'd0);
    // R3: next cycle is idle, so no response
    @(posedge clk);
    #1;
    chk_quiet("R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule